// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block is the guard logic between software and the program/erase engine of an on-chip flash array. Software sets a control register that holds a write-enable bit, a program bit, an erase bit and two verify bits. It also sets two per-block erase-enable registers and an emulation bit, which marks the flash as overlaid by RAM. The controller decides from these whether a request to program or erase is granted. It drives mode outputs and a per-block erase-enable vector to the engine.

While an operation is in progress, the controller watches for events that break the operating protocol: an access that reads the array (including instruction fetches and vector reads), an exception entry, or a sleep request. Any of these sets a sticky error flag and aborts the operation on the same clock edge. All register contents are kept. Entry into program or erase mode stays locked out until reset. The verify modes remain usable while the flag is set.

Top module: `flash_guard`

## Requirements
- R1: A program or erase mode is entered only by a control-register write whose data has the write-enable bit (bit 0) at 1. A write with bit 0 at 0 leaves both modes inactive even when the program bit (bit 1) or erase bit (bit 2) is 1.
- R2: `blkEraseEn` equals the concatenation {erase register at address 3, erase register at address 2}, with block n on bit n, while erase mode is active. It is all zeros otherwise. With both registers at zero, no block is enabled.
- R3: While the emulation bit (address 1, bit 0) is 1, neither program nor erase mode is active. Writing it to 1 aborts an active mode on that edge, and a control write made while it is 1 enters no mode.
- R4: A pulse on `arrayRead` during program or erase mode sets the error flag (control bit 7) and ends the mode on the next edge. The same pulse with no mode active has no effect on the flag.
- R5: A pulse on `excEntry` or `sleepReq` during program or erase mode sets the error flag and ends the mode on the next edge.
- R6: When the error flag sets, the control register's lower bits and both erase registers keep their values.
- R7: While the error flag is 1, no control write enters program or erase mode. `pvActive` (bit 3) and `evActive` (bit 4) still follow their bits ANDed with write-enable and with the emulation bit being 0.
- R8: The error flag can be cleared only by reset. Writes to control bit 7 have no effect, and once set the flag stays set.
- R9: A control write with both the program bit and the erase bit at 1 enters neither mode.
- R10: Reads return the current values: address 0 gives {error, 2'b0, ev, pv, erase, prog, wen}, address 1 gives the emulation bit in bit 0, and addresses 2 and 3 give the erase registers.
- R11: After reset, all registers, mode outputs and `blkEraseEn` are zero.
- R12: A granted control write makes `progActive` or `eraseActive` 1 from the next clock edge. A later control write with that bit at 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address |
| regWr | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| arrayRead | input | 1 | A flash array read, fetch or vector read this cycle |
| excEntry | input | 1 | Non-reset exception entry this cycle |
| sleepReq | input | 1 | Sleep request this cycle |
| progActive | output | 1 | Program mode active |
| eraseActive | output | 1 | Erase mode active |
| pvActive | output | 1 | Program-verify active |
| evActive | output | 1 | Erase-verify active |
| blkEraseEn | output | 16 | Per-block erase enable |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled on the rising edge. They also assume that reset is held low from time zero so that the flag and mode state start cleared. The bench changes every input only on the falling clock edge and holds each event high for exactly one cycle. It issues only one register write per cycle, so a control write and an emulation write never coincide.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int DATA_W      = 8;
  localparam int ERASE_REGS  = 2;
  localparam int NUM_BLOCKS  = DATA_W * ERASE_REGS;
  localparam int NUM_REGS    = 2 + ERASE_REGS;
  localparam int ADDR_W      = $clog2(NUM_REGS);

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_EMU    = 1;
  localparam int ADDR_ERASE0 = 2;

  // control register bit positions
  localparam int CB_WEN   = 0;
  localparam int CB_PROG  = 1;
  localparam int CB_ERASE = 2;
  localparam int CB_PV    = 3;
  localparam int CB_EV    = 4;
  localparam int CB_ERR   = 7;
  localparam int CTRL_W   = 5;   // stored writable bits
  localparam int EB_ON    = 0;   // emulation bit position

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_PROG  = 2'd1,
    MODE_ERASE = 2'd2
  } mode_e;

  typedef struct packed {
    logic                  setErr;
    logic                  wrCtrl;
    logic                  wrEmu;
    logic [ERASE_REGS-1:0] wrErase;
  } strobe_t;
endpackage

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              emuBit,
  input  logic              errFlag,
  input  logic              arrayRead,
  input  logic              excEntry,
  input  logic              sleepReq,
  output strobe_t           strobes,
  output mode_e             mode
);
  mode_e modeNext;
  logic  errEvent;
  logic  inMode;

  assign inMode   = (mode != MODE_IDLE);
  assign errEvent = inMode && (arrayRead || excEntry || sleepReq);

  // address decode into datapath strobes
  always_comb begin
    strobes        = '0;
    strobes.setErr = errEvent;
    if (regWr) begin
      strobes.wrCtrl = (regAddr == ADDR_W'(ADDR_CTRL));
      strobes.wrEmu  = (regAddr == ADDR_W'(ADDR_EMU));
      for (int i = 0; i < ERASE_REGS; i++)
        strobes.wrErase[i] = (regAddr == ADDR_W'(ADDR_ERASE0 + i));
    end
  end

  // mode state machine
  always_comb begin
    modeNext = mode;
    if (errEvent) begin
      modeNext = MODE_IDLE;
    end else if (strobes.wrCtrl) begin
      modeNext = MODE_IDLE;
      if (regWrData[CB_WEN] && !emuBit && !errFlag) begin
        if (regWrData[CB_PROG] && !regWrData[CB_ERASE])
          modeNext = MODE_PROG;
        else if (regWrData[CB_ERASE] && !regWrData[CB_PROG])
          modeNext = MODE_ERASE;
      end
    end else if (strobes.wrEmu && regWrData[EB_ON]) begin
      modeNext = MODE_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_IDLE;
    else       mode <= modeNext;
  end
endmodule

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  mode_e                 mode,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  output logic                  emuBit,
  output logic                  errFlag,
  output logic                  wenBit,
  output logic                  progActive,
  output logic                  eraseActive,
  output logic                  pvActive,
  output logic                  evActive,
  output logic [NUM_BLOCKS-1:0] blkEraseEn
);
  logic [CTRL_W-1:0]                 ctrlBits;
  logic [ERASE_REGS-1:0][DATA_W-1:0] eraseRegs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ctrlBits <= '0;
    else if (strobes.wrCtrl) ctrlBits <= regWrData[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              emuBit <= 1'b0;
    else if (strobes.wrEmu) emuBit <= regWrData[EB_ON];
  end

  // sticky: only reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errFlag <= 1'b0;
    else if (strobes.setErr) errFlag <= 1'b1;
  end

  for (genvar g = 0; g < ERASE_REGS; g++) begin : g_erase
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   eraseRegs[g] <= '0;
      else if (strobes.wrErase[g]) eraseRegs[g] <= regWrData;
    end
  end

  assign wenBit      = ctrlBits[CB_WEN];
  assign progActive  = (mode == MODE_PROG);
  assign eraseActive = (mode == MODE_ERASE);
  assign pvActive    = ctrlBits[CB_PV] && wenBit && !emuBit;
  assign evActive    = ctrlBits[CB_EV] && wenBit && !emuBit;
  assign blkEraseEn  = eraseActive ? eraseRegs : '0;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_CTRL)) begin
      regRdData[CTRL_W-1:0] = ctrlBits;
      regRdData[CB_ERR]     = errFlag;
    end else if (regAddr == ADDR_W'(ADDR_EMU)) begin
      regRdData[EB_ON] = emuBit;
    end
    for (int i = 0; i < ERASE_REGS; i++)
      if (regAddr == ADDR_W'(ADDR_ERASE0 + i)) regRdData = eraseRegs[i];
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  arrayRead,
  input  logic                  excEntry,
  input  logic                  sleepReq,
  output logic                  progActive,
  output logic                  eraseActive,
  output logic                  pvActive,
  output logic                  evActive,
  output logic [NUM_BLOCKS-1:0] blkEraseEn
);
  strobe_t strobes;
  mode_e   mode;
  logic    emuBit;
  logic    errFlag;
  logic    wenBit;

  flash_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWr     (regWr),
    .regWrData (regWrData),
    .emuBit    (emuBit),
    .errFlag   (errFlag),
    .arrayRead (arrayRead),
    .excEntry  (excEntry),
    .sleepReq  (sleepReq),
    .strobes   (strobes),
    .mode      (mode)
  );

  flash_guard_regs u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .mode        (mode),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .emuBit      (emuBit),
    .errFlag     (errFlag),
    .wenBit      (wenBit),
    .progActive  (progActive),
    .eraseActive (eraseActive),
    .pvActive    (pvActive),
    .evActive    (evActive),
    .blkEraseEn  (blkEraseEn)
  );
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk
  import flash_guard_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  arrayRead,
  input logic                  excEntry,
  input logic                  sleepReq,
  input logic                  progActive,
  input logic                  eraseActive,
  input logic [NUM_BLOCKS-1:0] blkEraseEn,
  input logic                  errFlag,
  input logic                  emuBit,
  input logic                  wenBit
);
  logic anyMode;
  assign anyMode = progActive || eraseActive;

  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(progActive && eraseActive)); // R9
  AST_WEN_REQUIRED: assert property (@(posedge clk) disable iff (!rstN)
    anyMode |-> wenBit); // R1
  AST_ERASE_VEC_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !eraseActive |-> (blkEraseEn == '0)); // R2
  AST_EMU_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    emuBit |-> !anyMode); // R3
  AST_READ_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (anyMode && arrayRead) |=> (errFlag && !anyMode)); // R4
  AST_EVENT_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (anyMode && (excEntry || sleepReq)) |=> (errFlag && !anyMode)); // R5
  AST_ERR_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !anyMode); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R8
endmodule

bind flash_guard flash_guard_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .arrayRead   (arrayRead),
  .excEntry    (excEntry),
  .sleepReq    (sleepReq),
  .progActive  (progActive),
  .eraseActive (eraseActive),
  .blkEraseEn  (blkEraseEn),
  .errFlag     (errFlag),
  .emuBit      (emuBit),
  .wenBit      (wenBit)
);

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        arrayRead = 1'b0;
  logic        excEntry = 1'b0;
  logic        sleepReq = 1'b0;
  logic        progActive, eraseActive, pvActive, evActive;
  logic [15:0] blkEraseEn;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_guard u_flash_guard (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .arrayRead(arrayRead),
    .excEntry(excEntry), .sleepReq(sleepReq), .progActive(progActive),
    .eraseActive(eraseActive), .pvActive(pvActive), .evActive(evActive),
    .blkEraseEn(blkEraseEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] modes();
    return {progActive, eraseActive, pvActive, evActive};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  // which: 0 array read, 1 exception, 2 sleep
  task automatic pulse(input int which);
    @(negedge clk);
    arrayRead = (which == 0); excEntry = (which == 1); sleepReq = (which == 2);
    @(negedge clk);
    arrayRead = 1'b0; excEntry = 1'b0; sleepReq = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R11 modes", modes(), 4'h0);
    chk("R11 blkEraseEn", blkEraseEn, 16'h0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R11 reg", d, 8'h00);
    end
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    do_reset();
    wr(2, 8'hA5); wr(3, 8'h3C); wr(1, 8'h01);
    rd(2, d); chk("R10 erase lo", d, 8'hA5);
    rd(3, d); chk("R10 erase hi", d, 8'h3C);
    rd(1, d); chk("R10 emu", d, 8'h01);
    wr(1, 8'h00);
    wr(0, 8'h98);
    rd(0, d); chk("R8 err bit not writable", d, 8'h18);
    chk("R7 verify needs wen", modes(), 4'h0);
  endtask

  task automatic t_wen();
    logic [7:0] d;
    do_reset();
    wr(0, 8'h02);
    chk("R1 no prog without wen", modes(), 4'h0);
    rd(0, d); chk("R1 prog bit stored", d, 8'h02);
    wr(0, 8'h03);
    chk("R12 prog entered", modes(), 4'h8);
    wr(0, 8'h01);
    chk("R12 prog left", modes(), 4'h0);
  endtask

  task automatic t_excl();
    do_reset();
    wr(0, 8'h07);
    chk("R9 both bits", modes(), 4'h0);
  endtask

  task automatic t_erase();
    do_reset();
    wr(2, 8'h81); wr(3, 8'h00);
    chk("R2 idle vector", blkEraseEn, 16'h0000);
    wr(0, 8'h05);
    chk("R12 erase entered", modes(), 4'h4);
    chk("R2 vector lo", blkEraseEn, 16'h0081);
    wr(3, 8'h40);
    chk("R2 vector hi", blkEraseEn, 16'h4081);
    wr(2, 8'h00); wr(3, 8'h00);
    chk("R2 all zero regs", blkEraseEn, 16'h0000);
    chk("R2 still erase mode", eraseActive, 1'b1);
    wr(0, 8'h01);
    chk("R12 erase left", modes(), 4'h0);
  endtask

  task automatic t_emu();
    do_reset();
    wr(1, 8'h01);
    wr(0, 8'h03);
    chk("R3 emu blocks entry", modes(), 4'h0);
    wr(1, 8'h00);
    wr(0, 8'h03);
    chk("R3 entry after emu clear", modes(), 4'h8);
    wr(1, 8'h01);
    chk("R3 emu aborts", modes(), 4'h0);
  endtask

  task automatic t_err_read();
    logic [7:0] d;
    do_reset();
    pulse(0);
    rd(0, d); chk("R4 idle read ignored", d, 8'h00);
    wr(2, 8'h55);
    wr(0, 8'h0B);
    chk("R12 prog with pv", modes(), 4'hA);
    pulse(0);
    chk("R4 read aborts, R7 pv kept", modes(), 4'h2);
    rd(0, d); chk("R6 ctrl kept with err", d, 8'h8B);
    rd(2, d); chk("R6 erase reg kept", d, 8'h55);
    wr(0, 8'h0B);
    chk("R7 no re-entry", modes(), 4'h2);
    wr(0, 8'h00);
    rd(0, d); chk("R8 err stays", d, 8'h80);
    do_reset();
    rd(0, d); chk("R8 reset clears err", d, 8'h00);
  endtask

  task automatic t_exc_sleep();
    logic [7:0] d;
    do_reset();
    wr(0, 8'h05);
    pulse(1);
    chk("R5 exception aborts", modes(), 4'h0);
    rd(0, d); chk("R5 exception sets err", d, 8'h85);
    wr(0, 8'h11);
    chk("R7 ev usable with err", modes(), 4'h1);
    do_reset();
    wr(0, 8'h03);
    pulse(2);
    chk("R5 sleep aborts", modes(), 4'h0);
    rd(0, d); chk("R5 sleep sets err", d, 8'h83);
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_wen();
    t_excl();
    t_erase();
    t_emu();
    t_err_read();
    t_exc_sleep();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule